// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is a target on a two-wire serial bus. It gives a bus controller access to a small bank of byte-wide registers. The block oversamples the clock line and the data line with its own system clock. It recognises start, repeated-start and stop conditions, shifts in a 7-bit address and answers only to its own address. A write transfer loads a register pointer from its first data byte. Every later byte is stored at the pointer, and the pointer then steps forward. A read transfer returns register contents from the current pointer, and the pointer steps forward after each byte sent.

Register contents reach the bus through a read path that needs a fixed number of system-clock cycles. Before each read byte, the target holds the clock line low until the fetched byte is in its shift register. A controller that honours clock stretching therefore never samples stale data. The pointer survives repeated starts and stops. This gives the usual "write pointer, repeated start, read burst" access pattern. Both bus lines are open-drain: the block only reports when it wants to pull a line low.

Top module: `i2c_regfile_target`

## Requirements
- R1: A falling SDA while SCL is high is a start condition. A rising SDA while SCL is high is a stop condition. After a stop, both drive-low outputs are deasserted and the block waits for the next start.
- R2: The first byte after a start is sampled on SCL rising edges, most significant bit first. Bits 7..1 are the address and bit 0 selects the direction (1 = read, 0 = write). When bits 7..1 equal DEV_ADDR (default 7'h2A), the target pulls SDA low through the ninth clock.
- R3: When the address does not match, the target never pulls SDA or SCL low, and the data bytes that follow leave the registers and the pointer unchanged until the next start.
- R4: In a write transfer, the first data byte loads the pointer from its low log2(N_REGS) bits. Each later data byte is stored in the register the pointer selects. The target acknowledges every data byte.
- R5: The pointer advances by one after each stored byte and after each byte sent in a read. From N_REGS-1 it wraps to 0. N_REGS is a power of two.
- R6: In a read transfer, the target presents the selected register most significant bit first. It changes SDA only while SCL is low, and it releases SDA during the controller's acknowledge bit.
- R7: A repeated start with no stop before it returns the target to address reception and keeps the pointer value.
- R8: Before each read byte, the target holds SCL low from the falling edge that ends the acknowledge bit until the fetched byte, FETCH_LAT cycles later, is loaded. No other bit of the byte is stretched.
- R9: A not-acknowledge (SDA high) from the controller after a read byte ends the data phase. SDA stays released until the next start or stop.
- R10: After reset, neither drive-low output is asserted. Register i holds 8'hA0 + i and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| scl_drive_low | output | 1 | 1 pulls the clock line low (stretching) |
| sda_drive_low | output | 1 | 1 pulls the data line low |

## Verification
The hardest situation to reach from the ports is clock stretching that the controller can actually see. The fetch must outlast the controller's own low phase. The controller must then wait for the line it has released to rise before it counts the bit. The bench models the bus as a wired AND of its controller and the target, and its controller waits on the resolved clock line while it counts stretch cycles. Its read bursts cross the last register, so the wrap in the middle of a burst is checked against a bench model of the pointer. Mismatched-address transfers then carry bytes that would move the pointer or overwrite register 0 if they were not ignored. A later read-back and a count of every drive-low cycle show whether the target stayed silent.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_LOAD,
    ST_RD_SETUP,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_IGNORE
  } rf_state_e;

  // Pointer step with wrap at the bank size.
  function automatic int unsigned rf_ptr_next(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // Value a register takes on reset.
  function automatic logic [7:0] rf_reset_value(input int unsigned idx);
    logic [7:0] low;
    low = idx[7:0];
    return 8'hA0 + low;
  endfunction

  // Address byte (address in 7..1, direction in 0) against the device address.
  function automatic logic rf_addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_line
      logic [2:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= 3'b111;
        else        sh_q <= {sh_q[1:0], raw[i]};
      end
      assign lvl[i]  = sh_q[1];
      assign rise[i] = sh_q[1] & ~sh_q[2];
      assign fall[i] = ~sh_q[1] & sh_q[2];
    end
  endgenerate
endmodule

// File: rtl/i2c_rf_busev.sv
module i2c_rf_busev (
  input  logic scl_lvl,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_scl_rise,
  output logic ev_scl_fall
);
  assign ev_start    = sda_fall & scl_lvl;
  assign ev_stop     = sda_rise & scl_lvl;
  assign ev_scl_rise = scl_rise;
  assign ev_scl_fall = scl_fall;
endmodule

// File: rtl/i2c_rf_bank.sv
module i2c_rf_bank import i2c_rf_pkg::*; #(
  parameter int N_REGS    = 8,
  parameter int FETCH_LAT = 48
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PW-1:0]         wr_idx,
  input  logic [7:0]            wr_byte,
  input  logic                  fetch_go,
  input  logic [PW-1:0]         fetch_idx,
  output logic                  fetch_done,
  output logic [7:0]            fetch_byte
);
  localparam int PW = (N_REGS > 1) ? $clog2(N_REGS) : 1;
  localparam int CW = $clog2(FETCH_LAT + 1);

  logic [7:0]    mem [N_REGS];
  logic [CW-1:0] wait_q;
  logic [PW-1:0] idx_q;

  generate
    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         mem[i] <= rf_reset_value(i);
        else if (wr_en && wr_idx == PW'(i)) mem[i] <= wr_byte;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q     <= '0;
      idx_q      <= '0;
      fetch_done <= 1'b0;
      fetch_byte <= '0;
    end else begin
      fetch_done <= 1'b0;
      if (fetch_go) begin
        wait_q <= CW'(FETCH_LAT);
        idx_q  <= fetch_idx;
      end else if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
        if (wait_q == CW'(1)) begin
          fetch_done <= 1'b1;
          fetch_byte <= mem[idx_q];
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target import i2c_rf_pkg::*; #(
  parameter logic [6:0] DEV_ADDR  = 7'h2A,
  parameter int         N_REGS    = 8,
  parameter int         FETCH_LAT = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_drive_low,
  output logic sda_drive_low
);
  localparam int PW = (N_REGS > 1) ? $clog2(N_REGS) : 1;

  // synchronised lines, bit 1 = clock, bit 0 = data
  logic [1:0] line_lvl, line_rise, line_fall;
  logic scl_lvl, sda_lvl;
  logic ev_start, ev_stop, ev_scl_rise, ev_scl_fall;

  i2c_rf_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({scl_i, sda_i}),
    .lvl(line_lvl), .rise(line_rise), .fall(line_fall)
  );

  assign scl_lvl = line_lvl[1];
  assign sda_lvl = line_lvl[0];

  i2c_rf_busev u_ev (
    .scl_lvl(scl_lvl), .scl_rise(line_rise[1]), .scl_fall(line_fall[1]),
    .sda_rise(line_rise[0]), .sda_fall(line_fall[0]),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_scl_rise(ev_scl_rise), .ev_scl_fall(ev_scl_fall)
  );

  rf_state_e     st_q;
  logic [3:0]    cnt_q;
  logic [7:0]    rx_q, tx_q;
  logic          rw_q, first_q, nack_q;
  logic [PW-1:0] ptr_q, ptr_after;
  logic          scl_hold_q, sda_hold_q;

  // named internal events
  logic quiet, addr_ack_go, wr_en, fetch_go, fetch_done, ptr_step, ignoring;
  logic [7:0] fetch_byte;

  assign quiet       = !ev_start && !ev_stop;
  assign ptr_after   = PW'(rf_ptr_next(int'(ptr_q), N_REGS));
  assign addr_ack_go = quiet && (st_q == ST_ADDR) && ev_scl_fall && (cnt_q == 4'd8)
                       && rf_addr_hit(rx_q, DEV_ADDR);
  assign wr_en       = quiet && (st_q == ST_WR_DATA) && ev_scl_fall && (cnt_q == 4'd8) && !first_q;
  assign fetch_go    = quiet && ev_scl_fall &&
                       (((st_q == ST_ADDR_ACK) && rw_q) || ((st_q == ST_RD_ACK) && !nack_q));
  assign ptr_step    = wr_en || (quiet && (st_q == ST_RD_DATA) && ev_scl_fall && (cnt_q == 4'd7));
  assign ignoring    = (st_q == ST_IGNORE);

  i2c_rf_bank #(.N_REGS(N_REGS), .FETCH_LAT(FETCH_LAT)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(ptr_q), .wr_byte(rx_q),
    .fetch_go(fetch_go), .fetch_idx(ptr_q),
    .fetch_done(fetch_done), .fetch_byte(fetch_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      rw_q       <= 1'b0;
      first_q    <= 1'b0;
      nack_q     <= 1'b0;
      ptr_q      <= '0;
      scl_hold_q <= 1'b0;
      sda_hold_q <= 1'b0;
    end else if (ev_start) begin
      st_q       <= ST_ADDR;
      cnt_q      <= '0;
      sda_hold_q <= 1'b0;
      scl_hold_q <= 1'b0;
    end else if (ev_stop) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      sda_hold_q <= 1'b0;
      scl_hold_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_WR_DATA: begin
          if (ev_scl_rise && cnt_q < 4'd8) begin
            rx_q  <= {rx_q[6:0], sda_lvl};
            cnt_q <= cnt_q + 4'd1;
          end else if (ev_scl_fall && cnt_q == 4'd8) begin
            if (st_q == ST_ADDR) begin
              if (addr_ack_go) begin
                st_q       <= ST_ADDR_ACK;
                sda_hold_q <= 1'b1;
                rw_q       <= rx_q[0];
              end else begin
                st_q <= ST_IGNORE;
              end
            end else begin
              ptr_q      <= first_q ? rx_q[PW-1:0] : ptr_after;
              first_q    <= 1'b0;
              sda_hold_q <= 1'b1;
              st_q       <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (ev_scl_fall) begin
            sda_hold_q <= 1'b0;
            cnt_q      <= '0;
            if (rw_q) begin
              scl_hold_q <= 1'b1;
              st_q       <= ST_RD_LOAD;
            end else begin
              first_q <= 1'b1;
              st_q    <= ST_WR_DATA;
            end
          end
        end
        ST_WR_ACK: begin
          if (ev_scl_fall) begin
            sda_hold_q <= 1'b0;
            cnt_q      <= '0;
            st_q       <= ST_WR_DATA;
          end
        end
        ST_RD_LOAD: begin
          if (fetch_done) begin
            tx_q       <= fetch_byte;
            sda_hold_q <= ~fetch_byte[7];
            cnt_q      <= '0;
            st_q       <= ST_RD_SETUP;
          end
        end
        ST_RD_SETUP: begin
          scl_hold_q <= 1'b0;
          st_q       <= ST_RD_DATA;
        end
        ST_RD_DATA: begin
          if (ev_scl_fall) begin
            if (cnt_q == 4'd7) begin
              sda_hold_q <= 1'b0;
              ptr_q      <= ptr_after;
              st_q       <= ST_RD_ACK;
            end else begin
              tx_q       <= {tx_q[6:0], 1'b0};
              sda_hold_q <= ~tx_q[6];
              cnt_q      <= cnt_q + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (ev_scl_rise) nack_q <= sda_lvl;
          if (ev_scl_fall) begin
            if (nack_q) begin
              st_q <= ST_IGNORE;
            end else begin
              scl_hold_q <= 1'b1;
              st_q       <= ST_RD_LOAD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign scl_drive_low = scl_hold_q;
  assign sda_drive_low = sda_hold_q;
endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker #(
  parameter int N_REGS = 8,
  parameter int PW     = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_start,
  input logic          ev_stop,
  input logic          scl_lvl,
  input logic          addr_ack_go,
  input logic          ignoring,
  input logic          ptr_step,
  input logic [PW-1:0] ptr_q,
  input logic          fetch_done,
  input logic          sda_drive_low,
  input logic          scl_drive_low
);
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!sda_drive_low && !scl_drive_low));

  p_ack_on_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack_go |=> sda_drive_low);

  p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> (!sda_drive_low && !scl_drive_low));

  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && ptr_q == PW'(N_REGS - 1)) |=> (ptr_q == '0));

  // R6: data line moves only while the synchronised clock is low
  p_sda_moves_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_drive_low) && !$past(ev_start) && !$past(ev_stop)) |-> !$past(scl_lvl));

  // R8: clock is let go only two cycles after the fetched byte arrives
  p_stretch_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_drive_low) && !$past(ev_start) && !$past(ev_stop)) |-> $past(fetch_done, 2));
endmodule

bind i2c_regfile_target i2c_rf_checker #(.N_REGS(N_REGS), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
  .scl_lvl(scl_lvl), .addr_ack_go(addr_ack_go), .ignoring(ignoring),
  .ptr_step(ptr_step), .ptr_q(ptr_q), .fetch_done(fetch_done),
  .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low)
);

// File: tb/i2c_regfile_target_tb_top.sv
module i2c_regfile_target_tb_top;
  localparam int H  = 25;
  localparam int NR = 8;
  localparam logic [7:0] AW = 8'h54;  // 7'h2A, write
  localparam logic [7:0] AR = 8'h55;  // 7'h2A, read

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_drive_low, sda_drive_low;
  wire  scl_w = m_scl & ~scl_drive_low;
  wire  sda_w = m_sda & ~sda_drive_low;

  i2c_regfile_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
  );

  int n_chk = 0, n_err = 0;
  int drive_cnt = 0;
  logic drv_at_sample;
  logic [7:0] mreg [NR];
  int mptr;

  logic [7:0] exp_v[$];
  string      exp_tag[$];
  logic [7:0] obs_v;
  event       obs_ev;

  always @(negedge clk) if (sda_drive_low || scl_drive_low) drive_cnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_high(output int st);
    m_scl = 1'b1;
    st = 0;
    @(negedge clk);
    while (!scl_w) begin st++; @(negedge clk); end
  endtask

  task automatic bit_cycle(input logic b, output logic r, output int st);
    m_sda = b;
    gap(H);
    go_high(st);
    gap(H / 2);
    r = sda_w;
    drv_at_sample = sda_drive_low;
    gap(H / 2);
    m_scl = 1'b0;
    gap(2);
  endtask

  task automatic do_start();
    int st;
    m_sda = 1'b1; gap(H);
    go_high(st); gap(H);
    m_sda = 1'b0; gap(H);
    m_scl = 1'b0; gap(H);
  endtask

  task automatic do_stop();
    int st;
    m_sda = 1'b0; gap(H);
    go_high(st); gap(H);
    m_sda = 1'b1; gap(H);
  endtask

  task automatic wbyte(input logic [7:0] v, output bit acked);
    logic r; int st;
    for (int i = 7; i >= 0; i--) bit_cycle(v[i], r, st);
    bit_cycle(1'b1, r, st);
    acked = !r;
  endtask

  // driver: push expected value, clock the byte in, hand it to the monitor
  task automatic read_expect(input string tag, input bit give_ack);
    logic r; int st, first_st, late;
    logic [7:0] v;
    exp_v.push_back(mreg[mptr]);
    exp_tag.push_back(tag);
    mptr = (mptr + 1) % NR;
    late = 0; first_st = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, r, st);
      v[i] = r;
      if (i == 7) first_st = st; else late += st;
    end
    bit_cycle(!give_ack, r, st);
    obs_v = v;
    -> obs_ev;
    chk(first_st >= 10, "R8 stretch before read byte", first_st, 10);
    chk(late == 0, "R8 no stretch inside byte", late, 0);
    if (!give_ack) chk(!drv_at_sample, "R6 released on ack bit", int'(drv_at_sample), 0);
  endtask

  initial begin
    forever begin
      @(obs_ev);
      if (exp_v.size() == 0) chk(1'b0, "R6 scoreboard underflow", 1, 0);
      else begin
        logic [7:0] e; string t;
        e = exp_v.pop_front();
        t = exp_tag.pop_front();
        chk(obs_v == e, t, obs_v, e);
      end
    end
  end

  task automatic finish_run();
    chk(exp_v.size() == 0, "R6 scoreboard drained", exp_v.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    bit a;
    int snap;
    logic r; int st;
    logic [7:0] v;
    for (int i = 0; i < NR; i++) mreg[i] = 8'hA0 + 8'(i);
    mptr = 0;
    gap(5);
    chk(!scl_drive_low && !sda_drive_low, "R10 reset releases lines",
        int'({scl_drive_low, sda_drive_low}), 0);
    rst_n = 1'b1;
    gap(10);

    // R10 reset contents and pointer 0, read without a pointer byte
    do_start();
    wbyte(AR, a); chk(a, "R2 read address acked", a, 1);
    read_expect("R10 reset value reg0", 1'b0);
    do_stop();

    // R4 write with pointer byte
    do_start();
    wbyte(AW, a); chk(a, "R2 write address acked", a, 1);
    wbyte(8'h02, a); chk(a, "R4 pointer byte acked", a, 1); mptr = 2;
    wbyte(8'h11, a); chk(a, "R4 data acked", a, 1); mreg[mptr] = 8'h11; mptr = (mptr + 1) % NR;
    wbyte(8'h22, a); chk(a, "R4 data acked", a, 1); mreg[mptr] = 8'h22; mptr = (mptr + 1) % NR;
    do_stop();
    gap(8);
    chk(!scl_drive_low && !sda_drive_low, "R1 released after stop",
        int'({scl_drive_low, sda_drive_low}), 0);

    // R5 read burst across the last register, then R9 nack ends data phase
    do_start();
    wbyte(AR, a); chk(a, "R2 read address acked", a, 1);
    read_expect("R6 burst reg4", 1'b1);
    read_expect("R6 burst reg5", 1'b1);
    read_expect("R6 burst reg6", 1'b1);
    read_expect("R5 burst reg7", 1'b1);
    read_expect("R5 wrap to reg0", 1'b0);
    snap = drive_cnt;
    v = '0;
    for (int i = 0; i < 9; i++) begin bit_cycle(1'b1, r, st); v = v | {7'd0, !r}; end
    chk(drive_cnt == snap && v == 8'd0, "R9 silent after nack", drive_cnt - snap, 0);
    do_stop();

    // R7 pointer write, repeated start, read
    do_start();
    wbyte(AW, a);
    wbyte(8'h03, a); mptr = 3;
    do_start();
    wbyte(AR, a); chk(a, "R7 address after repeated start acked", a, 1);
    read_expect("R7 read at written pointer", 1'b1);
    read_expect("R7 next register", 1'b0);
    do_stop();

    // R7 pointer kept past a stored byte across repeated start
    do_start();
    wbyte(AW, a);
    wbyte(8'h06, a); mptr = 6;
    wbyte(8'h66, a); mreg[mptr] = 8'h66; mptr = (mptr + 1) % NR;
    do_start();
    wbyte(AR, a);
    read_expect("R7 pointer retained", 1'b0);
    do_stop();

    // R3 mismatched address, write and read
    snap = drive_cnt;
    do_start();
    wbyte(8'h56, a); chk(!a, "R3 foreign write address not acked", a, 0);
    wbyte(8'h00, a); chk(!a, "R3 foreign data not acked", a, 0);
    wbyte(8'h99, a);
    do_stop();
    do_start();
    wbyte(8'h57, a); chk(!a, "R3 foreign read address not acked", a, 0);
    for (int i = 7; i >= 0; i--) begin bit_cycle(1'b1, r, st); v[i] = r; end
    bit_cycle(1'b1, r, st);
    chk(v == 8'hFF, "R3 no data on foreign read", v, 8'hFF);
    do_stop();
    chk(drive_cnt == snap, "R3 lines never driven", drive_cnt - snap, 0);
    read_expect_dummy: begin end
    do_start();
    wbyte(AR, a);
    read_expect("R3 pointer untouched", 1'b0);
    do_stop();
    do_start();
    wbyte(AW, a); wbyte(8'h00, a); mptr = 0;
    do_start();
    wbyte(AR, a);
    read_expect("R3 reg0 untouched", 1'b1);
    read_expect("R3 reg1 untouched", 1'b0);
    do_stop();

    // R5 write wrap
    do_start();
    wbyte(AW, a);
    wbyte(8'h07, a); mptr = 7;
    wbyte(8'hAA, a); mreg[mptr] = 8'hAA; mptr = (mptr + 1) % NR;
    wbyte(8'hBB, a); chk(a, "R5 byte after wrap acked", a, 1); mreg[mptr] = 8'hBB; mptr = (mptr + 1) % NR;
    do_stop();
    do_start();
    wbyte(AR, a);
    read_expect("R5 pointer after write wrap", 1'b0);
    do_stop();
    do_start();
    wbyte(AW, a); wbyte(8'h07, a); mptr = 7;
    do_start();
    wbyte(AR, a);
    read_expect("R5 reg7 written", 1'b1);
    read_expect("R5 reg0 written after wrap", 1'b0);
    do_stop();

    gap(20);
    finish_run();
  end
endmodule